// File: doc/BRIEF.md
# SPI Controller Interrupt Bank

This block collects the interrupt sources of an SPI master and presents them to a host through a small register window. Two of the sources are sticky events: a mode fault reported as a one-cycle pulse by the bus-contention detector, and a transmit-FIFO low-water event raised when the transmit fill level falls under a programmable watermark. The other two are live FIFO levels: transmit FIFO full and receive FIFO holding data. All four share one bit layout across the status view, the mask view and the two write-only ports that edit the mask.

The host arms sources by writing ones to a set port and disarms them by writing ones to a clear port, so no read-modify-write of the mask is ever needed. Sticky status bits are acknowledged by writing ones to the status word. A single interrupt line is high whenever any armed source is active. The same window also carries the watermark setting and the receive data port, where a read hands out one byte and pulses a pop strobe to the receive FIFO.

Top module: `spi_irq_bank`

## Requirements
- R1: After reset the mask reads 0, the sticky bits (1 and 2) read 0, the watermark at offset 0x28 reads 1 and `irq_out` is low.
- R2: A write to offset 0x08 sets every mask bit whose write-data bit is 1 and leaves the others unchanged; the mask has 7 bits (bits 6..0), write-data bits above bit 6 have no effect, and the mask reads back at offset 0x10.
- R3: A write to offset 0x0C clears every mask bit whose write-data bit is 1 and leaves the others unchanged.
- R4: The status word at offset 0x04 carries mode fault in bit 1, transmit low-water in bit 2, transmit full (level equal to the FIFO depth, 128) in bit 3 and receive not empty (level not zero) in bit 4; bits 0, 5, 6 and above read 0.
- R5: Bit 1 is set by a mode-fault pulse and stays set until a write to 0x04 with data bit 1 equal to 1; writing 0 there leaves it set.
- R6: Bit 2 is set in the cycle after the condition "transmit level below watermark" turns from false to true (by a level change or a watermark change), stays set after the level recovers, and is cleared by a write to 0x04 with data bit 2 equal to 1.
- R7: Bits 3 and 4 follow the FIFO levels in the same cycle, and a write of ones to them at 0x04 has no effect.
- R8: When a sticky event and a write-one-to-clear of the same bit occur in the same cycle, the bit is set afterwards.
- R9: `irq_out` equals the OR over all bits of (status AND mask), with no added delay.
- R10: The watermark at offset 0x28 is read/write with 8 bits taken from write-data bits 7..0.
- R11: A read of offset 0x20 returns `rx_byte` in bits 7..0 and drives `rx_pop` high for that read cycle; reads of other offsets keep `rx_pop` low. Reads of the write-only offsets 0x08 and 0x0C return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 6 | Byte offset of the access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid in the read cycle |
| mode_fault_evt | input | 1 | One-cycle mode-fault pulse |
| tx_level | input | 8 | Transmit FIFO fill level |
| rx_level | input | 8 | Receive FIFO fill level |
| rx_byte | input | 8 | Byte at the head of the receive FIFO |
| rx_pop | output | 1 | Pop request to the receive FIFO |
| irq_out | output | 1 | Interrupt request |

## Verification
The two functions that can land on one clock edge are the setting of a sticky bit by its source and its acknowledgement by a one written to the status word. The bench provokes this by driving the mode-fault pulse together with a clearing write, and by dropping the transmit level under the watermark in the same cycle as a clearing write to bit 2. It judges the outcome by reading the status word afterwards and expecting the bit still set, then clearing it alone and expecting it gone.

// File: rtl/spi_irq_pkg.sv
`timescale 1ns/1ps
package spi_irq_pkg;
  localparam int REG_AW  = 6;
  localparam int NUM_SRC = 7;

  localparam logic [REG_AW-1:0] OFS_STATUS = 6'h04;
  localparam logic [REG_AW-1:0] OFS_ARM    = 6'h08;
  localparam logic [REG_AW-1:0] OFS_DISARM = 6'h0C;
  localparam logic [REG_AW-1:0] OFS_MASK   = 6'h10;
  localparam logic [REG_AW-1:0] OFS_RXDATA = 6'h20;
  localparam logic [REG_AW-1:0] OFS_WMARK  = 6'h28;

  localparam int B_MODF   = 1;
  localparam int B_TXLOW  = 2;
  localparam int B_TXFULL = 3;
  localparam int B_RXNE   = 4;

  // any armed source active
  function automatic logic irq_pending(input logic [NUM_SRC-1:0] sts,
                                       input logic [NUM_SRC-1:0] msk);
    return |(sts & msk);
  endfunction

  // low-water condition of the transmit FIFO
  function automatic logic below_mark(input logic [7:0] lvl,
                                      input logic [7:0] mark);
    return lvl < mark;
  endfunction
endpackage

// File: rtl/spi_irq_decode.sv
`timescale 1ns/1ps
module spi_irq_decode
  import spi_irq_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int LVL_W  = 8
) (
  input  logic                  reg_wr,
  input  logic                  reg_rd,
  input  logic [REG_AW-1:0]     reg_addr,
  input  logic [NUM_SRC-1:0]    status_word,
  input  logic [NUM_SRC-1:0]    mask_word,
  input  logic [LVL_W-1:0]      wmark_word,
  input  logic [7:0]            rx_byte,
  output logic                  wr_status,
  output logic                  wr_arm,
  output logic                  wr_disarm,
  output logic                  wr_wmark,
  output logic                  rx_pop,
  output logic [DATA_W-1:0]     reg_rdata
);
  assign wr_status = reg_wr && (reg_addr == OFS_STATUS);
  assign wr_arm    = reg_wr && (reg_addr == OFS_ARM);
  assign wr_disarm = reg_wr && (reg_addr == OFS_DISARM);
  assign wr_wmark  = reg_wr && (reg_addr == OFS_WMARK);
  assign rx_pop    = reg_rd && (reg_addr == OFS_RXDATA);

  always_comb begin
    reg_rdata = '0;
    if (reg_rd) begin
      case (reg_addr)
        OFS_STATUS: reg_rdata[NUM_SRC-1:0] = status_word;
        OFS_MASK:   reg_rdata[NUM_SRC-1:0] = mask_word;
        OFS_WMARK:  reg_rdata[LVL_W-1:0]   = wmark_word;
        OFS_RXDATA: reg_rdata[7:0]         = rx_byte;
        default:    reg_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/spi_irq_wmark.sv
`timescale 1ns/1ps
module spi_irq_wmark #(
  parameter int LVL_W     = 8,
  parameter int RESET_VAL = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [LVL_W-1:0] wdata,
  output logic [LVL_W-1:0] mark
);
  always_ff @(posedge clk) begin
    if (!rst_n)     mark <= LVL_W'(RESET_VAL);
    else if (wr_en) mark <= wdata;
  end

  AST_WMARK_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> mark == $past(wdata)) else $error("watermark load"); // R10
endmodule

// File: rtl/spi_irq_mask.sv
`timescale 1ns/1ps
module spi_irq_mask
  import spi_irq_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               arm_en,
  input  logic               disarm_en,
  input  logic [NUM_SRC-1:0] bits,
  output logic [NUM_SRC-1:0] mask
);
  for (genvar b = 0; b < NUM_SRC; b++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rst_n)                      mask[b] <= 1'b0;
      else if (arm_en && bits[b])      mask[b] <= 1'b1;
      else if (disarm_en && bits[b])   mask[b] <= 1'b0;
    end
  end

  AST_ARM_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    arm_en |=> (mask & $past(bits)) == $past(bits)) else $error("arm"); // R2
  AST_DISARM_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    disarm_en |=> (mask & $past(bits)) == '0) else $error("disarm"); // R3
  AST_MASK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !arm_en && !disarm_en |=> $stable(mask)) else $error("mask hold"); // R2
endmodule

// File: rtl/spi_irq_status.sv
`timescale 1ns/1ps
module spi_irq_status
  import spi_irq_pkg::*;
#(
  parameter int LVL_W      = 8,
  parameter int FIFO_DEPTH = 128
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               mode_fault_evt,
  input  logic [LVL_W-1:0]   tx_level,
  input  logic [LVL_W-1:0]   rx_level,
  input  logic [LVL_W-1:0]   mark,
  input  logic               ack_en,
  input  logic               ack_modf,
  input  logic               ack_txlow,
  output logic [NUM_SRC-1:0] status
);
  logic sticky_modf, sticky_txlow;
  logic below_now, below_prev;
  logic txlow_evt;        // condition entered this cycle
  logic txfull_live, rxne_live;

  assign below_now   = below_mark(tx_level, mark);
  assign txlow_evt   = below_now && !below_prev;
  assign txfull_live = (tx_level == LVL_W'(FIFO_DEPTH));
  assign rxne_live   = (rx_level != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      below_prev   <= 1'b1;
      sticky_modf  <= 1'b0;
      sticky_txlow <= 1'b0;
    end else begin
      below_prev <= below_now;
      if (mode_fault_evt)              sticky_modf <= 1'b1;
      else if (ack_en && ack_modf)     sticky_modf <= 1'b0;
      if (txlow_evt)                   sticky_txlow <= 1'b1;
      else if (ack_en && ack_txlow)    sticky_txlow <= 1'b0;
    end
  end

  always_comb begin
    status           = '0;
    status[B_MODF]   = sticky_modf;
    status[B_TXLOW]  = sticky_txlow;
    status[B_TXFULL] = txfull_live;
    status[B_RXNE]   = rxne_live;
  end

  AST_MODF_EVT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    mode_fault_evt |=> status[B_MODF]) else $error("modf event"); // R8
  AST_MODF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    status[B_MODF] && !(ack_en && ack_modf) |=> status[B_MODF]) else $error("modf sticky"); // R5
  AST_TXLOW_EVT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    txlow_evt |=> status[B_TXLOW]) else $error("txlow event"); // R6
  AST_TXLOW_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    ack_en && ack_txlow && !txlow_evt |=> !status[B_TXLOW]) else $error("txlow ack"); // R6
endmodule

// File: rtl/spi_irq_bank.sv
`timescale 1ns/1ps
module spi_irq_bank
  import spi_irq_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int FIFO_DEPTH = 128,
  parameter int WMARK_RST  = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              mode_fault_evt,
  input  logic [7:0]        tx_level,
  input  logic [7:0]        rx_level,
  input  logic [7:0]        rx_byte,
  output logic              rx_pop,
  output logic              irq_out
);
  localparam int LVL_W = 8;

  logic               wr_status, wr_arm, wr_disarm, wr_wmark;
  logic [NUM_SRC-1:0] status_w, mask_w;
  logic [LVL_W-1:0]   mark_w;

  spi_irq_decode #(.DATA_W(DATA_W), .LVL_W(LVL_W)) u_dec (
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .status_word(status_w), .mask_word(mask_w), .wmark_word(mark_w),
    .rx_byte(rx_byte), .wr_status(wr_status), .wr_arm(wr_arm),
    .wr_disarm(wr_disarm), .wr_wmark(wr_wmark), .rx_pop(rx_pop),
    .reg_rdata(reg_rdata)
  );

  spi_irq_wmark #(.LVL_W(LVL_W), .RESET_VAL(WMARK_RST)) u_wmark (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_wmark),
    .wdata(reg_wdata[LVL_W-1:0]), .mark(mark_w)
  );

  spi_irq_mask u_mask (
    .clk(clk), .rst_n(rst_n), .arm_en(wr_arm), .disarm_en(wr_disarm),
    .bits(reg_wdata[NUM_SRC-1:0]), .mask(mask_w)
  );

  spi_irq_status #(.LVL_W(LVL_W), .FIFO_DEPTH(FIFO_DEPTH)) u_sts (
    .clk(clk), .rst_n(rst_n), .mode_fault_evt(mode_fault_evt),
    .tx_level(tx_level), .rx_level(rx_level), .mark(mark_w),
    .ack_en(wr_status), .ack_modf(reg_wdata[B_MODF]),
    .ack_txlow(reg_wdata[B_TXLOW]), .status(status_w)
  );

  assign irq_out = irq_pending(status_w, mask_w);

  AST_IRQ_NEEDS_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> mask_w != '0) else $error("irq without mask"); // R9
  AST_IRQ_NEEDS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> status_w != '0) else $error("irq without source"); // R9
endmodule

// File: tb/tb_spi_irq_bank.sv
`timescale 1ns/1ps
module tb_spi_irq_bank;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [5:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        mode_fault_evt = 1'b0;
  logic [7:0]  tx_level = 8'd64, rx_level = 8'd0, rx_byte = 8'd0;
  logic        rx_pop, irq_out;

  int checks = 0, errors = 0;
  logic done = 1'b0;

  always #10 clk = ~clk;

  spi_irq_bank dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .mode_fault_evt(mode_fault_evt), .tx_level(tx_level),
    .rx_level(rx_level), .rx_byte(rx_byte), .rx_pop(rx_pop),
    .irq_out(irq_out)
  );

  task automatic check(input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  logic pop_seen;
  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    #2 d = reg_rdata; pop_seen = rx_pop;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic set_tx(input logic [7:0] l);
    @(negedge clk);
    tx_level = l;
    @(negedge clk);
  endtask

  task automatic pulse_modf();
    @(negedge clk);
    mode_fault_evt = 1'b1;
    @(negedge clk);
    mode_fault_evt = 1'b0;
  endtask

  // s[0] modf, s[1] txlow, s[2] txfull, s[3] rxne
  task automatic set_status(input logic [3:0] s);
    set_tx(8'd64);
    wr(6'h04, 32'h06);
    rx_level = s[3] ? 8'd3 : 8'd0;
    if (s[0]) pulse_modf();
    if (s[1]) set_tx(8'd0);
    set_tx(s[2] ? 8'd128 : 8'd64);
  endtask

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(6'h10, d); check("R1 mask", d, 32'h0);
    rd(6'h04, d); check("R1 status", d, 32'h0);
    rd(6'h28, d); check("R1 wmark", d, 32'h1);
    check("R1 irq", {31'b0, irq_out}, 32'h0);

    // R11 write-only offsets read 0, rx data port
    wr(6'h08, 32'h7F);
    rd(6'h08, d); check("R11 arm reads 0", d, 32'h0);
    rd(6'h0C, d); check("R11 disarm reads 0", d, 32'h0);
    rx_byte = 8'hA5;
    rd(6'h20, d); check("R11 rx data", d, 32'hA5);
    check("R11 pop on rx read", {31'b0, pop_seen}, 32'h1);
    rd(6'h10, d); check("R11 no pop elsewhere", {31'b0, pop_seen}, 32'h0);

    // R2 / R3 sweep: every arm pattern against a spread of disarm patterns
    for (int v = 0; v < 128; v++) begin
      wr(6'h0C, 32'hFFFF_FFFF);
      wr(6'h08, 32'hFFFF_FF80 | 32'(v));
      rd(6'h10, d); check("R2 arm", d, 32'(v));
      for (int u = 0; u < 128; u += 9) begin
        wr(6'h0C, 32'(u));
        rd(6'h10, d); check("R3 disarm", d, 32'(v & ~u & 8'h7F));
        wr(6'h08, 32'(v));
      end
      wr(6'h08, 32'h0);
      rd(6'h10, d); check("R2 zero write", d, 32'(v));
    end

    // R4/R9 sweep: every status combination under every mask
    for (int s = 0; s < 16; s++) begin
      set_status(4'(s));
      rd(6'h04, d); check("R4 layout", d, 32'(s) << 1);
      for (int m = 0; m < 128; m++) begin
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 6'h0C; reg_wdata = 32'h7F;
        @(negedge clk);
        reg_addr = 6'h08; reg_wdata = 32'(m);
        @(negedge clk);
        reg_wr = 1'b0;
        #2 check("R9 irq", {31'b0, irq_out}, {31'b0, |((s << 1) & m)});
      end
    end
    wr(6'h0C, 32'h7F);

    // R5 sticky mode fault
    set_status(4'b0000);
    pulse_modf();
    repeat (4) @(negedge clk);
    rd(6'h04, d); check("R5 held", d & 32'h2, 32'h2);
    wr(6'h04, 32'h0);
    rd(6'h04, d); check("R5 zero write", d & 32'h2, 32'h2);
    wr(6'h04, 32'h2);
    rd(6'h04, d); check("R5 cleared", d & 32'h2, 32'h0);

    // R6 low-water sticky, level and watermark triggers
    set_tx(8'd0);
    set_tx(8'd64);
    rd(6'h04, d); check("R6 persists", d & 32'h4, 32'h4);
    wr(6'h04, 32'h4);
    rd(6'h04, d); check("R6 cleared", d & 32'h4, 32'h0);
    wr(6'h28, 32'd100);
    rd(6'h28, d); check("R10 wmark rw", d, 32'd100);
    rd(6'h04, d); check("R6 mark raise", d & 32'h4, 32'h4);
    wr(6'h04, 32'h4);
    set_tx(8'd50);
    rd(6'h04, d); check("R6 stays below no event", d & 32'h4, 32'h0);
    wr(6'h28, 32'h1FF);
    rd(6'h28, d); check("R10 width", d, 32'hFF);
    wr(6'h28, 32'd1);
    set_tx(8'd64);

    // R7 live bits ignore acknowledge
    rx_level = 8'd5; tx_level = 8'd128;
    wr(6'h04, 32'h18);
    rd(6'h04, d); check("R7 live kept", d & 32'h18, 32'h18);
    rx_level = 8'd0; tx_level = 8'd127;
    #2;
    rd(6'h04, d); check("R7 live follow", d & 32'h18, 32'h0);
    set_tx(8'd64);
    wr(6'h04, 32'h6);

    // R8 event and acknowledge in the same cycle
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 6'h04; reg_wdata = 32'h2; mode_fault_evt = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; mode_fault_evt = 1'b0;
    rd(6'h04, d); check("R8 modf event wins", d & 32'h2, 32'h2);
    wr(6'h04, 32'h2);
    rd(6'h04, d); check("R8 modf clear alone", d & 32'h2, 32'h0);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 6'h04; reg_wdata = 32'h4; tx_level = 8'd0;
    @(negedge clk);
    reg_wr = 1'b0;
    rd(6'h04, d); check("R8 txlow event wins", d & 32'h4, 32'h4);
    wr(6'h04, 32'h4);
    rd(6'h04, d); check("R8 txlow clear alone", d & 32'h4, 32'h0);

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (190000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule